// File: doc/BRIEF.md
# Multichannel Averaging Output Router

This block takes one signed 16-bit sample from each of four converter channels per input strobe. For each of four output lanes it produces either an arithmetic average of a channel group or one raw channel picked by a selector. Averaging extends precision by two bits, so every lane carries an 18-bit word in quarter-LSB units. A width-mode control presents either the full word or its upper 16 bits, sign-extended into the 18-bit lane.

Software writes the configuration through a single load strobe. The configuration holds a global averaging enable, a width mode, a 2-bit averaging code per lane and a 2-bit channel selector per lane. A fixed per-lane table maps the codes to averaging groups. The group is the low pair (channels 0 and 1), the high pair (channels 2 and 3) or all four channels. Lanes whose code has no table entry carry their routed raw channel. Results are registered and appear one clock after the input strobe, together with a valid strobe.

Top module: `avg_lane_router`

## Requirements
- R1: While reset is low, and after it is released until the first strobe, `out_valid` is 0 and every lane is 0. Reset loads the default configuration: averaging off, 16-bit view, and lane i routed to channel i.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. Lane words hold their value across cycles without `in_valid`.
- R3: For a raw lane, the selector value k in `cfg_sel[2i+1:2i]` routes channel k to lane i. The 18-bit word is the sample shifted left by two.
- R4: While the global averaging enable is 0, every lane carries its routed raw channel, whatever its code.
- R5: With averaging enabled, a pair average gives the signed sum of the two samples shifted left by one. The lane code is `cfg_code[2i+1:2i]`. Lane 0 gives the low pair for code 2'b10, lane 3 gives the high pair for code 2'b10, lane 1 gives the high pair for code 2'b11, and lane 2 gives the low pair for code 2'b11.
- R6: With averaging enabled, code 2'b11 on lane 0 or lane 3 gives the 18-bit signed sum of all four samples.
- R7: Codes 2'b00 and 2'b01 on any lane, and code 2'b10 on lanes 1 and 2, give the routed raw channel.
- R8: In 16-bit mode (`cfg_wide` = 0), lane bits [15:0] are bits [17:2] of the 18-bit word, and bits [17:16] copy its sign bit.
- R9: In 18-bit mode (`cfg_wide` = 1), the lane carries the full 18-bit word.
- R10: A configuration presented with `cfg_load` is captured at that clock edge. A sample strobed in the same cycle still uses the old configuration, and every later sample uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One sample per channel is present |
| ch_data | input | 64 | Channel k sample in bits [16k+15:16k], signed |
| cfg_load | input | 1 | Capture the configuration inputs |
| cfg_avg_en | input | 1 | Global averaging enable |
| cfg_wide | input | 1 | 1: 18-bit view, 0: upper-16-bit view |
| cfg_code | input | 8 | Per-lane averaging codes, lane i in [2i+1:2i] |
| cfg_sel | input | 8 | Per-lane raw channel selector, lane i in [2i+1:2i] |
| out_valid | output | 1 | Lane words updated this cycle |
| lane_out | output | 72 | Lane i word in bits [18i+17:18i] |

## Verification
A wrong configuration register has no internal consequence of its own. It shows up as a wrong lane word on the first strobe after the load, one clock later, so the bench compares every lane on every clock against a behavioural model. Arithmetic faults in the sums show only for particular sample values. For that reason the stimulus includes full-scale positive and negative samples and sign-mixed ones, which exercise carries into the top two bits. Timing faults in the configuration capture are covered by strobing a sample in the same cycle as a load.

// File: rtl/alr_pkg.sv
package alr_pkg;
  localparam int NUM_CH   = 4;
  localparam int NUM_LANE = 4;
  localparam int SEL_W    = $clog2(NUM_CH);
  localparam int CODE_W   = 2;

  typedef enum logic [1:0] {
    SRC_RAW     = 2'd0,
    SRC_PAIR_LO = 2'd1,
    SRC_PAIR_HI = 2'd2,
    SRC_QUAD    = 2'd3
  } src_e;

  // Fixed per-lane table from averaging code to source group.
  function automatic src_e lane_source(input int lane, input logic [CODE_W-1:0] code,
                                       input logic en);
    src_e s;
    s = SRC_RAW;
    if (en) begin
      case (lane)
        0: if (code == 2'b10) s = SRC_PAIR_LO; else if (code == 2'b11) s = SRC_QUAD;
        1: if (code == 2'b11) s = SRC_PAIR_HI;
        2: if (code == 2'b11) s = SRC_PAIR_LO;
        3: if (code == 2'b10) s = SRC_PAIR_HI; else if (code == 2'b11) s = SRC_QUAD;
        default: s = SRC_RAW;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/alr_cfg_regs.sv
module alr_cfg_regs
  import alr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       avg_en_in,
  input  logic                       wide_in,
  input  logic [NUM_LANE*CODE_W-1:0] code_in,
  input  logic [NUM_LANE*SEL_W-1:0]  sel_in,
  output logic                       avg_en_q,
  output logic                       wide_q,
  output logic [NUM_LANE*CODE_W-1:0] code_q,
  output logic [NUM_LANE*SEL_W-1:0]  sel_q
);
  logic                       avg_en_d;
  logic                       wide_d;
  logic [NUM_LANE*CODE_W-1:0] code_d;
  logic [NUM_LANE*SEL_W-1:0]  sel_d;
  logic [NUM_LANE*SEL_W-1:0]  sel_default;

  // Lane i defaults to channel i.
  for (genvar g = 0; g < NUM_LANE; g++) begin : g_def
    assign sel_default[g*SEL_W +: SEL_W] = SEL_W'(g % NUM_CH);
  end

  always_comb begin
    avg_en_d = avg_en_q;
    wide_d   = wide_q;
    code_d   = code_q;
    sel_d    = sel_q;
    if (load) begin
      avg_en_d = avg_en_in;
      wide_d   = wide_in;
      code_d   = code_in;
      sel_d    = sel_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_en_q <= 1'b0;
      wide_q   <= 1'b0;
      code_q   <= '0;
      sel_q    <= sel_default;
    end else begin
      avg_en_q <= avg_en_d;
      wide_q   <= wide_d;
      code_q   <= code_d;
      sel_q    <= sel_d;
    end
  end
endmodule

// File: rtl/alr_sum_unit.sv
module alr_sum_unit
  import alr_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  localparam int OUT_W   = SAMPLE_W + 2
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] ch_flat,
  output logic [OUT_W-1:0]           pair_lo,
  output logic [OUT_W-1:0]           pair_hi,
  output logic [OUT_W-1:0]           quad
);
  logic [SAMPLE_W-1:0] s [NUM_CH];
  logic [SAMPLE_W:0]   lo_sum;
  logic [SAMPLE_W:0]   hi_sum;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign s[g] = ch_flat[g*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    lo_sum  = {s[0][SAMPLE_W-1], s[0]} + {s[1][SAMPLE_W-1], s[1]};
    hi_sum  = {s[2][SAMPLE_W-1], s[2]} + {s[3][SAMPLE_W-1], s[3]};
    // Pair sum is 17 bits; one left shift puts it in quarter-LSB units.
    pair_lo = {lo_sum, 1'b0};
    pair_hi = {hi_sum, 1'b0};
    // Four-way sum is already in quarter-LSB units.
    quad    = {lo_sum[SAMPLE_W], lo_sum} + {hi_sum[SAMPLE_W], hi_sum};
  end
endmodule

// File: rtl/alr_lane_select.sv
module alr_lane_select
  import alr_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int LANE     = 0,
  localparam int OUT_W   = SAMPLE_W + 2
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] ch_flat,
  input  logic [OUT_W-1:0]           pair_lo,
  input  logic [OUT_W-1:0]           pair_hi,
  input  logic [OUT_W-1:0]           quad,
  input  logic [CODE_W-1:0]          code,
  input  logic [SEL_W-1:0]           sel,
  input  logic                       avg_en,
  input  logic                       wide,
  output logic [OUT_W-1:0]           word
);
  src_e                src;
  logic [SAMPLE_W-1:0] raw;
  logic [OUT_W-1:0]    full;

  always_comb begin
    src = lane_source(LANE, code, avg_en);
    raw = ch_flat[sel*SAMPLE_W +: SAMPLE_W];
    case (src)
      SRC_PAIR_LO: full = pair_lo;
      SRC_PAIR_HI: full = pair_hi;
      SRC_QUAD:    full = quad;
      default:     full = {raw, 2'b00};
    endcase
    if (wide) word = full;
    else      word = {{2{full[OUT_W-1]}}, full[OUT_W-1:2]};
  end
endmodule

// File: rtl/avg_lane_router.sv
module avg_lane_router
  import alr_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  localparam int OUT_W   = SAMPLE_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0] ch_data,
  input  logic                       cfg_load,
  input  logic                       cfg_avg_en,
  input  logic                       cfg_wide,
  input  logic [NUM_LANE*CODE_W-1:0] cfg_code,
  input  logic [NUM_LANE*SEL_W-1:0]  cfg_sel,
  output logic                       out_valid,
  output logic [NUM_LANE*OUT_W-1:0]  lane_out
);
  logic                       cfg_en_q;
  logic                       cfg_wide_q;
  logic [NUM_LANE*CODE_W-1:0] cfg_code_q;
  logic [NUM_LANE*SEL_W-1:0]  cfg_sel_q;
  logic [OUT_W-1:0]           pair_lo;
  logic [OUT_W-1:0]           pair_hi;
  logic [OUT_W-1:0]           quad;
  logic [NUM_LANE*OUT_W-1:0]  lane_word;
  logic [NUM_LANE*OUT_W-1:0]  lane_d;
  logic                       valid_d;

  alr_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .avg_en_in (cfg_avg_en),
    .wide_in   (cfg_wide),
    .code_in   (cfg_code),
    .sel_in    (cfg_sel),
    .avg_en_q  (cfg_en_q),
    .wide_q    (cfg_wide_q),
    .code_q    (cfg_code_q),
    .sel_q     (cfg_sel_q)
  );

  alr_sum_unit #(.SAMPLE_W(SAMPLE_W)) u_sum (
    .ch_flat (ch_data),
    .pair_lo (pair_lo),
    .pair_hi (pair_hi),
    .quad    (quad)
  );

  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
    alr_lane_select #(.SAMPLE_W(SAMPLE_W), .LANE(g)) u_sel (
      .ch_flat (ch_data),
      .pair_lo (pair_lo),
      .pair_hi (pair_hi),
      .quad    (quad),
      .code    (cfg_code_q[g*CODE_W +: CODE_W]),
      .sel     (cfg_sel_q[g*SEL_W +: SEL_W]),
      .avg_en  (cfg_en_q),
      .wide    (cfg_wide_q),
      .word    (lane_word[g*OUT_W +: OUT_W])
    );
  end

  always_comb begin
    valid_d = in_valid;
    lane_d  = in_valid ? lane_word : lane_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lane_out  <= '0;
    end else begin
      out_valid <= valid_d;
      lane_out  <= lane_d;
    end
  end
endmodule

// File: rtl/alr_checker.sv
module alr_checker
  import alr_pkg::*;
#(
  parameter int OUT_W = 18
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      out_valid,
  input logic [NUM_LANE*OUT_W-1:0] lane_out,
  input logic                      avg_en_q,
  input logic                      wide_q
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (out_valid == 1'b0 && lane_out == '0)
        else $error("outputs not cleared in reset");
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(lane_out));

  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane_chk
    assert_narrow_sext_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && !$past(wide_q)) |->
        (lane_out[g*OUT_W+OUT_W-1] == lane_out[g*OUT_W+OUT_W-3] &&
         lane_out[g*OUT_W+OUT_W-2] == lane_out[g*OUT_W+OUT_W-3]));
    assert_raw_lsbs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(wide_q) && !$past(avg_en_q)) |->
        (lane_out[g*OUT_W +: 2] == 2'b00));
  end
endmodule

bind avg_lane_router alr_checker #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .lane_out  (lane_out),
  .avg_en_q  (cfg_en_q),
  .wide_q    (cfg_wide_q)
);

// File: tb/tb_avg_lane_router.sv
module tb_avg_lane_router;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int OW = 18;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [4*SW-1:0] ch_data;
  logic          cfg_load;
  logic          cfg_avg_en;
  logic          cfg_wide;
  logic [7:0]    cfg_code;
  logic [7:0]    cfg_sel;
  logic          out_valid;
  logic [4*OW-1:0] lane_out;

  int    n_tests;
  int    n_fail;
  string cur_req;

  // Behavioural model state
  int    m_sel [4];
  int    m_code[4];
  bit    m_en;
  bit    m_wide;
  bit    m_valid;
  logic [OW-1:0] m_lane[4];

  avg_lane_router dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ch_data(ch_data),
    .cfg_load(cfg_load), .cfg_avg_en(cfg_avg_en), .cfg_wide(cfg_wide),
    .cfg_code(cfg_code), .cfg_sel(cfg_sel), .out_valid(out_valid), .lane_out(lane_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int samp(int k);
    return int'($signed(ch_data[k*SW +: SW]));
  endfunction

  function automatic logic [OW-1:0] expect_lane(int l);
    int w;
    int r;
    int c;
    c = m_code[l];
    w = samp(m_sel[l]) * 4;
    if (m_en) begin
      if ((l == 0 && c == 2) || (l == 2 && c == 3)) w = (samp(0) + samp(1)) * 2;
      if ((l == 3 && c == 2) || (l == 1 && c == 3)) w = (samp(2) + samp(3)) * 2;
      if ((l == 0 || l == 3) && c == 3) w = samp(0) + samp(1) + samp(2) + samp(3);
    end
    r = m_wide ? w : (w >>> 2);
    return r[OW-1:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_wide = 0; m_valid = 0;
      for (int i = 0; i < 4; i++) begin
        m_sel[i] = i; m_code[i] = 0; m_lane[i] = '0;
      end
    end else begin
      m_valid = in_valid;
      if (in_valid)
        for (int i = 0; i < 4; i++) m_lane[i] = expect_lane(i);
      if (cfg_load) begin
        m_en = cfg_avg_en; m_wide = cfg_wide;
        for (int i = 0; i < 4; i++) begin
          m_sel[i]  = int'(cfg_sel[2*i +: 2]);
          m_code[i] = int'(cfg_code[2*i +: 2]);
        end
      end
    end
  end

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    n_tests++;
    if (out_valid !== m_valid) begin
      n_fail++;
      $display("FAIL %s out_valid got %0b exp %0b", (rst_n ? cur_req : "R1"), out_valid, m_valid);
    end
    for (int i = 0; i < 4; i++) begin
      n_tests++;
      if (lane_out[i*OW +: OW] !== m_lane[i]) begin
        n_fail++;
        $display("FAIL %s lane %0d got %h exp %h", (rst_n ? cur_req : "R1"), i,
                 lane_out[i*OW +: OW], m_lane[i]);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    cfg_load = 1'b0;
  endtask

  task automatic load_cfg(bit en, bit wide, logic [7:0] code, logic [7:0] sel);
    cfg_load = 1'b1; cfg_avg_en = en; cfg_wide = wide; cfg_code = code; cfg_sel = sel;
  endtask

  task automatic push_rand(int n, int pct);
    for (int i = 0; i < n; i++) begin
      in_valid = ($urandom_range(99) < pct);
      ch_data  = {$urandom, $urandom};
      tick();
    end
    in_valid = 1'b0;
  endtask

  task automatic push_fixed(logic [SW-1:0] a, logic [SW-1:0] b, logic [SW-1:0] c,
                            logic [SW-1:0] d);
    in_valid = 1'b1; ch_data = {d, c, b, a};
    tick();
    in_valid = 1'b0;
  endtask

  task automatic extremes();
    push_fixed(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF);
    push_fixed(16'h8000, 16'h8000, 16'h8000, 16'h8000);
    push_fixed(16'h7FFF, 16'h8000, 16'h0001, 16'hFFFF);
    push_fixed(16'hFFFF, 16'hFFFE, 16'h8001, 16'h7FFE);
  endtask

  initial begin
    n_tests = 0; n_fail = 0; cur_req = "R1";
    rst_n = 1'b0; in_valid = 1'b0; ch_data = '0;
    cfg_load = 1'b0; cfg_avg_en = 1'b0; cfg_wide = 1'b0; cfg_code = '0; cfg_sel = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick(); tick();
    // R1: default routing and 16-bit view after reset
    push_rand(8, 100);
    extremes();
    // R3: raw routing under several selector patterns, 18-bit view
    cur_req = "R3";
    load_cfg(0, 1, 8'h00, 8'b00_01_10_11); tick(); push_rand(6, 100);
    load_cfg(0, 1, 8'h00, 8'b10_10_10_10); tick(); push_rand(6, 100);
    load_cfg(0, 1, 8'h00, 8'b01_00_11_10); tick(); push_rand(6, 100);
    // R2: sparse strobes, hold between them
    cur_req = "R2";
    push_rand(60, 40);
    // R4: codes set but global enable clear
    cur_req = "R4";
    load_cfg(0, 1, 8'hFF, 8'b11_10_01_00); tick(); push_rand(8, 100); extremes();
    load_cfg(0, 1, 8'hBE, 8'b00_11_00_11); tick(); push_rand(8, 100);
    // R5: pair averages in 18-bit view, incl. full-scale values
    cur_req = "R5";
    load_cfg(1, 1, 8'hBE, 8'b11_10_01_00); tick(); push_rand(10, 100); extremes();
    // R6: four-channel average on lanes 0 and 3
    cur_req = "R6";
    load_cfg(1, 1, 8'hC3, 8'b01_10_11_00); tick(); push_rand(10, 100); extremes();
    // R7: codes with no table entry
    cur_req = "R7";
    load_cfg(1, 1, 8'h29, 8'b00_01_10_11); tick(); push_rand(10, 100); extremes();
    load_cfg(1, 1, 8'h55, 8'b11_11_00_00); tick(); push_rand(6, 100);
    // R8: 16-bit view of averages and raw data
    cur_req = "R8";
    load_cfg(1, 0, 8'hBE, 8'b11_10_01_00); tick(); push_rand(8, 100); extremes();
    load_cfg(1, 0, 8'hC3, 8'b11_10_01_00); tick(); push_rand(8, 100); extremes();
    // R9: 18-bit view with mixed sources
    cur_req = "R9";
    load_cfg(1, 1, 8'hFE, 8'b10_00_11_01); tick(); push_rand(8, 100); extremes();
    // R10: load in the same cycle as a strobe
    cur_req = "R10";
    for (int i = 0; i < 30; i++) begin
      load_cfg($urandom_range(1), $urandom_range(1), 8'($urandom), 8'($urandom));
      in_valid = 1'b1; ch_data = {$urandom, $urandom};
      tick();
    end
    in_valid = 1'b0;
    // Mixed random traffic with loads
    cur_req = "R2";
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(9) == 0)
        load_cfg($urandom_range(1), $urandom_range(1), 8'($urandom), 8'($urandom));
      in_valid = ($urandom_range(3) != 0);
      ch_data  = {$urandom, $urandom};
      tick();
    end
    in_valid = 1'b0;
    tick(); tick();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired during %s", cur_req);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule